// File: doc/BRIEF.md
# Serial Baud Clock Generator

This block produces the bit timing for a serial port that can work either asynchronously or with a shared clock. A 12-bit reloading down-counter divides the system clock. A two-bit mode code and a double-speed flag then turn that counter's tick into strobes. Each strobe is a single-cycle enable: one marks where the transmitter shifts out its next bit, one marks where the receiver takes a sample, and a square-wave clock is produced for the pin when the port is the clock master.

In asynchronous operation the receive strobe is the oversampling tick. There are 16 such ticks per bit, or 8 when double speed is on, and the transmit strobe marks each bit boundary. As clock master, the block toggles its clock output on every counter tick. The receive strobe precedes the rising edge and the transmit strobe precedes the falling edge. As clock slave, the incoming serial clock is passed through a two-flop synchronizer and a delay flop, and its detected edges drive the same two strobes.

The mode decode is a rate selector with four values:
- RATE_X16: asynchronous, normal speed.
- RATE_X8: asynchronous, double speed.
- RATE_X2: synchronous master.
- RATE_EXT: synchronous slave.

The master clock phase is a two-state machine with states PH_LOW and PH_HIGH:
- PH_LOW to PH_HIGH happens on a counter tick in RATE_X2.
- PH_HIGH to PH_LOW happens on a counter tick in RATE_X2.
- Either state goes to PH_LOW on a divisor write or whenever the rate is not RATE_X2.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, `sclk_out` and `tx_shift_en` are low. After reset the divisor is 0, so in mode 00 `rx_sample_en` is high in every cycle.
- R2: A cycle with `cfg_div_wr` high loads `cfg_div` (value D, 0 to 4095) and restarts the counter, the bit counter and the clock phase. No strobe occurs in that cycle in the asynchronous modes. Counting the cycle after the write as cycle 1, the first counter tick falls in cycle D+1.
- R3: In the asynchronous modes (code 00, or 11 which behaves the same), `rx_sample_en` pulses once every D+1 cycles.
- R4: In asynchronous normal speed (`cfg_dbl`=0), `tx_shift_en` pulses once every 16·(D+1) cycles. The first pulse falls in cycle 16·(D+1) after a write, together with the 16th receive tick.
- R5: In asynchronous double speed (`cfg_dbl`=1), `tx_shift_en` pulses once every 8·(D+1) cycles. The receive tick rate is unchanged, so a bit spans 8 samples.
- R6: In synchronous master mode (code 01), `sclk_out` is a square wave of period 2·(D+1). It is low in cycles 1 to D+1 after a write and high in cycles D+2 to 2·(D+1).
- R7: In master mode, `rx_sample_en` pulses in cycles k·(D+1) for odd k (the cycle before `sclk_out` rises). `tx_shift_en` pulses in cycles k·(D+1) for even k (the cycle before it falls).
- R8: `cfg_dbl` has no effect in the synchronous modes (codes 01 and 10).
- R9: In synchronous slave mode (code 10), a rise of `ext_sclk_in` gives one `rx_sample_en` pulse, and a fall gives one `tx_shift_en` pulse. The pulse is visible in the cycle after the second rising clock edge that follows the pin change.
- R10: Outside master mode `sclk_out` stays low. In slave mode the two strobes are never high together.
- R11: Mode code 11 produces the same strobes as code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00/11 asynchronous, 01 synchronous master, 10 synchronous slave |
| cfg_dbl | input | 1 | Double-speed request, used only in asynchronous modes |
| cfg_div | input | 12 | Divisor value D |
| cfg_div_wr | input | 1 | Load strobe for `cfg_div` |
| ext_sclk_in | input | 1 | Serial clock from the remote master |
| tx_shift_en | output | 1 | Transmit shift strobe |
| rx_sample_en | output | 1 | Receive sample / oversampling strobe |
| sclk_out | output | 1 | Generated serial clock in master mode |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor, oversampling of 16 and 8, and two synchronizer stages. With these, even the largest divisor of 4095 finishes a full asynchronous bit in 65,536 cycles. That makes it practical to compare every output in every cycle against arithmetic predictions for divisors 0, 1, 2 and 4095 in each rate. The slave path is exercised with pin toggles at several spacings. Each toggle lands on an exact expected cycle offset, which pins down the latency through the synchronizer.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC     = 2'b00,
        MODE_SYNC_MSTR = 2'b01,
        MODE_SYNC_SLV  = 2'b10,
        MODE_ASYNC_ALT = 2'b11
    } baud_mode_e;

    typedef enum logic [1:0] {
        RATE_X16,
        RATE_X8,
        RATE_X2,
        RATE_EXT
    } baud_rate_e;

    typedef enum logic {
        PH_LOW,
        PH_HIGH
    } sclk_phase_e;

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Zero count means reload this cycle; a load cycle never ticks.
    assign tick = (cnt_q == '0) && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= load_val;
            cnt_q <= load_val;
        end else if (cnt_q == '0) begin
            cnt_q <= div_q;
        end else begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end
endmodule

// File: rtl/baud_bit_divider.sv
module baud_bit_divider #(
    parameter int OSR_NORM = 16,
    parameter int OSR_DBL  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic dbl,
    output logic bit_pulse
);
    localparam int OCW = $clog2(OSR_NORM);
    localparam logic [OCW-1:0] LAST_N = OCW'(OSR_NORM - 1);
    localparam logic [OCW-1:0] LAST_D = OCW'(OSR_DBL - 1);

    logic [OCW-1:0] oc_q;
    logic [OCW-1:0] last_w;

    assign last_w    = dbl ? LAST_D : LAST_N;
    assign bit_pulse = tick && (oc_q >= last_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_q <= '0;
        end else if (clear) begin
            oc_q <= '0;
        end else if (tick) begin
            if (oc_q >= last_w) oc_q <= '0;
            else                oc_q <= oc_q + OCW'(1);
        end
    end
endmodule

// File: rtl/baud_sync_edge.sv
module baud_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    // STAGES synchronizer flops followed by one delay flop.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise =  sh_q[STAGES-1] && !sh_q[STAGES];
    assign fall = !sh_q[STAGES-1] &&  sh_q[STAGES];
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int OSR_NORM    = 16,
    parameter int OSR_DBL     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_dbl,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_div_wr,
    input  logic             ext_sclk_in,
    output logic             tx_shift_en,
    output logic             rx_sample_en,
    output logic             sclk_out
);
    baud_mode_e  mode;
    baud_rate_e  rate;
    sclk_phase_e ph_q, ph_d;
    logic        tick;
    logic        bit_pulse;
    logic        ext_rise, ext_fall;

    assign mode = baud_mode_e'(cfg_mode);

    // Rate selection; double speed is honoured only asynchronously.
    always_comb begin
        unique case (mode)
            MODE_ASYNC, MODE_ASYNC_ALT: rate = cfg_dbl ? RATE_X8 : RATE_X16;
            MODE_SYNC_MSTR:             rate = RATE_X2;
            MODE_SYNC_SLV:              rate = RATE_EXT;
            default:                    rate = RATE_X16;
        endcase
    end

    baud_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_div_wr),
        .load_val (cfg_div),
        .tick     (tick)
    );

    baud_bit_divider #(.OSR_NORM(OSR_NORM), .OSR_DBL(OSR_DBL)) u_bit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_div_wr),
        .tick      (tick),
        .dbl       (rate == RATE_X8),
        .bit_pulse (bit_pulse)
    );

    baud_sync_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_sclk_in),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    // Master clock phase: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_LOW;
        else        ph_q <= ph_d;
    end

    // Master clock phase: next state.
    always_comb begin
        ph_d = ph_q;
        if (cfg_div_wr || rate != RATE_X2) begin
            ph_d = PH_LOW;
        end else if (tick) begin
            unique case (ph_q)
                PH_LOW:  ph_d = PH_HIGH;
                PH_HIGH: ph_d = PH_LOW;
                default: ph_d = PH_LOW;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sclk_out     = (ph_q == PH_HIGH);
        tx_shift_en  = 1'b0;
        rx_sample_en = 1'b0;
        unique case (rate)
            RATE_X16, RATE_X8: begin
                rx_sample_en = tick;
                tx_shift_en  = bit_pulse;
            end
            RATE_X2: begin
                rx_sample_en = tick && (ph_q == PH_LOW);
                tx_shift_en  = tick && (ph_q == PH_HIGH);
            end
            RATE_EXT: begin
                rx_sample_en = ext_rise;
                tx_shift_en  = ext_fall;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_div_wr,
    input logic       ext_sclk_in,
    input logic       tx_shift_en,
    input logic       rx_sample_en,
    input logic       sclk_out
);
    logic [1:0] age_q;
    logic       is_async, is_mstr, is_slv;

    assign is_async = (cfg_mode == 2'b00) || (cfg_mode == 2'b11);
    assign is_mstr  = (cfg_mode == 2'b01);
    assign is_slv   = (cfg_mode == 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    a_r2_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_div_wr && is_async) |-> (!rx_sample_en && !tx_shift_en));

    a_r7_rise_follows_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mstr && rx_sample_en && !cfg_div_wr) |=> sclk_out);

    a_r7_fall_follows_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mstr && tx_shift_en && !cfg_div_wr) |=> !sclk_out);

    a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_mstr) |=> !sclk_out);

    a_r10_slave_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        is_slv |-> !(rx_sample_en && tx_shift_en));

    a_r9_slave_rise_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && is_slv && $past(ext_sclk_in, 2) && !$past(ext_sclk_in, 3))
            |-> rx_sample_en);

    a_r9_slave_fall_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && is_slv && !$past(ext_sclk_in, 2) && $past(ext_sclk_in, 3))
            |-> tx_shift_en);
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mode     (cfg_mode),
    .cfg_div_wr   (cfg_div_wr),
    .ext_sclk_in  (ext_sclk_in),
    .tx_shift_en  (tx_shift_en),
    .rx_sample_en (rx_sample_en),
    .sclk_out     (sclk_out)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_dbl = 1'b0;
    logic [11:0] cfg_div = '0;
    logic        cfg_div_wr = 1'b0;
    logic        ext_sclk_in = 1'b0;
    logic        tx_shift_en, rx_sample_en, sclk_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dbl(cfg_dbl),
        .cfg_div(cfg_div), .cfg_div_wr(cfg_div_wr), .ext_sclk_in(ext_sclk_in),
        .tx_shift_en(tx_shift_en), .rx_sample_en(rx_sample_en), .sclk_out(sclk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write divisor with mode/dbl; returns after the write cycle.
    task automatic write_div(input logic [1:0] m, input logic d, input int dv, input string req);
        @(posedge clk); #1;
        cfg_mode = m; cfg_dbl = d; cfg_div = 12'(dv); cfg_div_wr = 1'b1;
        @(negedge clk);
        if (m == 2'b00 || m == 2'b11)
            chk(!rx_sample_en && !tx_shift_en, {req, " R2 no strobe in write cycle"},
                int'(rx_sample_en | tx_shift_en), 0);
        @(posedge clk); #1;
        cfg_div_wr = 1'b0;
    endtask

    // Asynchronous sweep: compares strobes every cycle against arithmetic.
    task automatic sweep_async(input logic [1:0] m, input logic d, input int dv,
                               input int nbits, input string req);
        int osr = d ? 8 : 16;
        int p = dv + 1;
        int bad_rx = 0, bad_tx = 0, bad_ck = 0;
        write_div(m, d, dv, req);
        for (int c = 1; c <= osr * p * nbits; c++) begin
            @(negedge clk);
            if (rx_sample_en !== ((c % p) == 0)) bad_rx++;
            if (tx_shift_en !== ((c % (osr * p)) == 0)) bad_tx++;
            if (sclk_out !== 1'b0) bad_ck++;
        end
        chk(bad_rx == 0, {req, " R3 rx tick every D+1"}, bad_rx, 0);
        chk(bad_tx == 0, {req, d ? " R5 tx every 8(D+1)" : " R4 tx every 16(D+1)"}, bad_tx, 0);
        chk(bad_ck == 0, {req, " R10 sclk low in async"}, bad_ck, 0);
    endtask

    // Master sweep: square wave and edge strobes.
    task automatic sweep_master(input logic d, input int dv, input int ncyc, input string req);
        int p = dv + 1;
        int bad_rx = 0, bad_tx = 0, bad_ck = 0;
        write_div(2'b01, d, dv, req);
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            if (rx_sample_en !== ((c % p) == 0 && ((c / p) % 2) == 1)) bad_rx++;
            if (tx_shift_en  !== ((c % p) == 0 && ((c / p) % 2) == 0)) bad_tx++;
            if (sclk_out !== ((((c - 1) / p) % 2) == 1)) bad_ck++;
        end
        chk(bad_ck == 0, {req, " R6 sclk square wave"}, bad_ck, 0);
        chk(bad_rx == 0, {req, d ? " R8 R7 rx strobe" : " R7 rx strobe"}, bad_rx, 0);
        chk(bad_tx == 0, {req, d ? " R8 R7 tx strobe" : " R7 tx strobe"}, bad_tx, 0);
    endtask

    // Slave: toggle pin, expect one strobe in the 3rd sampled cycle.
    task automatic slave_edge(input logic lvl, input int gap, input string req);
        int bad = 0;
        @(posedge clk); #1;
        ext_sclk_in = lvl;
        for (int c = 1; c <= gap; c++) begin
            @(negedge clk);
            if (rx_sample_en !== (lvl  && c == 3)) bad++;
            if (tx_shift_en  !== (!lvl && c == 3)) bad++;
            if (sclk_out !== 1'b0) bad++;
        end
        chk(bad == 0, {req, lvl ? " R9 R8 rise strobe" : " R9 R8 fall strobe"}, bad, 0);
    endtask

    initial begin
        int bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sclk_out == 1'b0, "R1 sclk low in reset", int'(sclk_out), 0);
        chk(tx_shift_en == 1'b0, "R1 tx low in reset", int'(tx_shift_en), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        bad = 0;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            if (rx_sample_en !== 1'b1) bad++;
        end
        chk(bad == 0, "R1 rx every cycle after reset", bad, 0);

        for (int i = 0; i < 4; i++) begin
            int dv = (i == 3) ? 4095 : i;
            int nb = (i == 3) ? 1 : 2;
            sweep_async(2'b00, 1'b0, dv, nb, "async-normal");
            sweep_async(2'b00, 1'b1, dv, nb, "async-double");
            sweep_master(1'b0, dv, (i == 3) ? 2 * (dv + 1) + 2 : 4 * (dv + 1) + 1, "master");
            sweep_master(1'b1, dv, (i == 3) ? 2 * (dv + 1) + 2 : 4 * (dv + 1) + 1, "master-dbl");
        end
        sweep_async(2'b11, 1'b0, 3, 2, "R11 code11");
        sweep_async(2'b11, 1'b1, 1, 2, "R11 code11-dbl");

        // R2: rewrite in the middle of a long count
        write_div(2'b00, 1'b0, 40, "R2 long");
        repeat (7) @(negedge clk);
        write_div(2'b00, 1'b0, 5, "R2 rewrite");
        bad = 0;
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (rx_sample_en !== (c == 6)) bad++;
        end
        chk(bad == 0, "R2 first tick D+1 after rewrite", bad, 0);

        // Slave mode with double speed requested
        write_div(2'b10, 1'b1, 7, "slave");
        repeat (4) @(negedge clk);
        slave_edge(1'b1, 6, "slave");
        slave_edge(1'b0, 4, "slave");
        slave_edge(1'b1, 5, "slave");
        slave_edge(1'b0, 8, "slave");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule